// File: doc/BRIEF.md
# Window-Based Address Translator

This block sits on the address path of a single bus master. It views the master's 32-bit byte address space as sixteen equal 256 MB windows, picked by the top four address bits. Each window has a table entry with two 4-bit fields. The first field names the target slave. The second field gives the window number that replaces the top address nibble, so the access lands in the matching window of that slave's own map. The address path is combinational. In the same cycle as a valid master address, the block drives the selected slave number and the rewritten address. If the window has no slave, it raises a decode-error flag instead of forwarding the access.

Software programs the table through a small 32-bit register port. Writes go into staging copies of the table, and translation ignores them. A write of 1 to a separate commit register loads all staged entries into the live table at once. Several windows can point at the same slave with different replacement numbers. This allows a contiguous region larger than one window to be mapped onto consecutive windows of one memory port.

Top module: `aperture_remap`

## Requirements
- R1: After reset, the staging and live tables hold all zeros. Every register reads 0, and every valid access reports a decode error.
- R2: The window index is address bits [31:28]. For a valid access, `xl_slave` carries the live slave field of that window in the same cycle.
- R3: `xl_addr` equals the input address with bits [31:28] replaced by the window's live replacement field and bits [27:0] unchanged.
- R4: A window whose live slave field is 0 gives `xl_err`=1, `xl_valid`=0 and `xl_slave`=0 for a valid access. A window with a nonzero slave field gives `xl_valid`=1 and `xl_err`=0.
- R5: Writes to the four table registers change the staging table only. Translation results do not change until a commit.
- R6: A write to the commit register (byte offset 0x10) with data bit 0 set copies the whole staging table into the live table at that clock edge. Translation uses the new table from the following cycle. A commit write with bit 0 clear has no effect.
- R7: Reads of offsets 0x0, 0x4, 0x8 and 0xC return the staging values. Reads of the commit register and of unused offsets return 0.
- R8: Register layout: 0x0 holds the slave fields of windows 0–7 and 0x4 holds those of windows 8–15. 0x8 and 0xC hold the replacement fields in the same grouping. Window w sits in bits [4(w mod 8)+3 : 4(w mod 8)] of its register.
- R9: While `in_valid` is 0, `xl_valid` and `xl_err` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Master address is valid |
| in_addr | input | 32 | Master byte address |
| xl_valid | output | 1 | Access forwarded to a slave |
| xl_err | output | 1 | Access hit an unmapped window |
| xl_slave | output | 4 | Selected slave number (0 when not forwarded) |
| xl_addr | output | 32 | Translated address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 5-bit register offset. With these values all sixteen windows, both register groups and the commit register can be reached. Random tables fill every nibble position. Random addresses land in every window, including the all-ones and window-edge addresses. Directed cases cover staged-but-uncommitted writes, commits with bit 0 clear, and two windows folded onto one slave.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              xl_valid,
  output logic              xl_err,
  output logic [3:0]        xl_slave,
  output logic [ADDR_W-1:0] xl_addr,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int LOW_W = ADDR_W - 4;
  localparam int NWIN  = 16;

  logic [31:0] stg_sel [2];
  logic [31:0] stg_off [2];
  logic [31:0] live_sel [2];
  logic [31:0] live_off [2];

  logic [2:0] wsel;
  logic       commit;
  assign wsel   = cfg_addr[4:2];
  assign commit = cfg_wr && wsel == 3'd4 && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        stg_sel[g]  <= '0;
        stg_off[g]  <= '0;
        live_sel[g] <= '0;
        live_off[g] <= '0;
      end
    end else begin
      if (cfg_wr && !wsel[2]) begin
        if (wsel[1]) stg_off[wsel[0]] <= cfg_wdata;
        else         stg_sel[wsel[0]] <= cfg_wdata;
      end
      if (commit) begin
        live_sel <= stg_sel;
        live_off <= stg_off;
      end
    end
  end

  always_comb begin
    case (wsel)
      3'd0: cfg_rdata = stg_sel[0];
      3'd1: cfg_rdata = stg_sel[1];
      3'd2: cfg_rdata = stg_off[0];
      3'd3: cfg_rdata = stg_off[1];
      default: cfg_rdata = '0;
    endcase
  end

  logic [3:0] win_sel [NWIN];
  logic [3:0] win_off [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_sel[w] = live_sel[w/8][4*(w%8) +: 4];
    assign win_off[w] = live_off[w/8][4*(w%8) +: 4];
  end

  logic [3:0] idx, hit_sel, hit_off;
  assign idx     = in_addr[ADDR_W-1 -: 4];
  assign hit_sel = win_sel[idx];
  assign hit_off = win_off[idx];

  assign xl_valid = in_valid && hit_sel != 4'd0;
  assign xl_err   = in_valid && hit_sel == 4'd0;
  assign xl_slave = xl_valid ? hit_sel : 4'd0;
  assign xl_addr  = {hit_off, in_addr[LOW_W-1:0]};

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_sel[0]) && $stable(live_sel[1]) &&
                $stable(live_off[0]) && $stable(live_off[1])); // R5

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_sel[0] == $past(stg_sel[0]) && live_sel[1] == $past(stg_sel[1]) &&
               live_off[0] == $past(stg_off[0]) && live_off[1] == $past(stg_off[1])); // R6

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xl_valid, xl_err})); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !xl_valid && !xl_err); // R9

  AST_COMMIT_READ0: assert property (@(posedge clk) disable iff (!rst_n)
    wsel[2] |-> cfg_rdata == 32'd0); // R7
endmodule

// File: tb/aperture_remap_test.sv
module aperture_remap_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] in_addr = 0;
  logic        xl_valid, xl_err;
  logic [3:0]  xl_slave;
  logic [31:0] xl_addr;
  logic        cfg_wr = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_stg [4];
  logic [31:0] m_live [4];

  always #2 clk = ~clk;

  aperture_remap uut (.*);

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [3:0] nib(input logic [31:0] r, input int w);
    return r[4*(w%8) +: 4];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (a[4:2] < 4) m_stg[a[3:2]] = d;
    if (a[4:2] == 4 && d[0]) m_live = m_stg;
  endtask

  task automatic rd(input string req, input logic [4:0] a);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, {32'd0, cfg_rdata}, {32'd0, (a[4:2] < 4) ? m_stg[a[3:2]] : 32'd0});
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic v);
    logic [3:0] s, o;
    int w;
    @(negedge clk);
    in_addr = a; in_valid = v;
    #1;
    w = a[31:28];
    s = nib(m_live[w/8], w);
    o = nib(m_live[2 + w/8], w);
    chk(req, {xl_valid, xl_err, xl_slave},
        {v && s != 0, v && s == 0, (v && s != 0) ? s : 4'd0});
    if (v) chk({req, " addr"}, {32'd0, xl_addr}, {32'd0, o, a[27:0]});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_stg[i] = 0; m_live[i] = 0; end
    #9 rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 5; i++) rd("R1 reset readback", 5'(i*4));
    for (int i = 0; i < 16; i++) probe("R1 reset decode", {4'(i), 28'(i*4097)}, 1);

    // R5 staged writes do not take effect; R8 layout via readback
    for (int i = 0; i < 4; i++) wr(5'(i*4), $urandom);
    for (int i = 0; i < 8; i++) probe("R5 staged no effect", $urandom, 1);
    for (int i = 0; i < 5; i++) rd("R7 R8 staged readback", 5'(i*4));
    rd("R7 unused offset", 5'h1C);

    // R6 commit with bit0 clear ignored
    wr(5'h10, 32'hFFFF_FFFE);
    for (int i = 0; i < 8; i++) probe("R6 clear commit ignored", $urandom, 1);
    wr(5'h10, 32'd1);
    for (int i = 0; i < 200; i++) probe("R2 R3 R4 random", $urandom, 1);
    for (int i = 0; i < 16; i++) begin
      probe("R3 window low edge", {4'(i), 28'h0}, 1);
      probe("R3 window high edge", {4'(i), 28'hFFF_FFFF}, 1);
    end

    // R8 directed: windows 8,9 -> slave 1 offsets 0,1; window 2 none; window 15 slave 6
    wr(5'h04, 32'h6000_0011);
    wr(5'h0C, 32'h0000_0010);
    wr(5'h00, 32'h0000_0033);
    probe("R5 before commit", 32'h8123_4567, 1);
    wr(5'h10, 32'd1);
    chk("R8 window8", {xl_valid, xl_slave}, {1'b1, 4'd1});
    probe("R8 fold w8", 32'h8123_4567, 1);
    chk("R8 fold w8 addr", xl_addr, 32'h0123_4567);
    probe("R8 fold w9", 32'h9ABC_DEF0, 1);
    chk("R8 fold w9 addr", xl_addr, 32'h1ABC_DEF0);
    probe("R8 w15", 32'hFFFF_FFFF, 1);
    chk("R8 w15 slave", xl_slave, 4'd6);
    probe("R4 unmapped", 32'h2000_0000, 1);
    chk("R4 unmapped err", {xl_err, xl_valid}, 2'b10);

    // R9 idle
    for (int i = 0; i < 10; i++) probe("R9 idle", $urandom, 0);
    // R7 commit register reads zero after write
    rd("R7 commit reads zero", 5'h10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule